// File: doc/BRIEF.md
# Four-Pair PWM Generator with H-Bridge Steering

This block drives eight pulse-width-modulated outputs arranged as four pairs. Each pair runs its own up-counter. A shared prescaler sets the counter's tick rate, and the counter wraps at a programmable length. Each pair shapes two waveforms from three compare values. The even output is a leading pulse. The odd output is a window between two compare points. Software reaches the block through a simple register port of 16-bit registers at fixed byte offsets.

Compare and length values first go into staging registers. A load request copies them into the active set, and each pair takes the copy at its own period wrap. In standard mode the request bit clears itself once every pair has taken the copy. In H-bridge mode the bit stays set, and each write of 1 starts exactly one more copy. H-bridge mode steers the waveforms of outputs 0 to 3. A direction bit holds one pair low while the other drives. An enable bit and a high-side-off bit gate the first two pairs. Inversion controls are available. An external sync input can restart all counters on its falling edge. Per-pair wrap flags and a trip flag feed one interrupt line and are cleared by writing 1s.

Top module: `pwm_quad`

## Requirements
- R1: After reset, all outputs and the interrupt line are 0, and every register reads 0.
- R2: While control bit 0 (master enable) is 0, all eight outputs are 0 and the counters and prescaler are held at 0.
- R3: Control bits 8:6 hold a code k, and a counter tick occurs every 2^(k+1) clocks. With length L the output period is (L+1)·2^(k+1) clocks.
- R4: For pair p, offsets 0x10+0x10·p, +0x4, +0x8 and +0xC hold staged values A, B, C and length L, and each reads back what was written. Output 2p is high while count < A. Output 2p+1 is high while B <= count < C. The count runs from 0 to L and then wraps to 0. Staged values have no effect until they are loaded.
- R5: Writing control bit 3 (load) as 1 makes each pair copy its staged values into its active set at its next wrap. In standard mode (control bit 1 = 0) the bit reads back 0 once every pair has copied.
- R6: In H-bridge mode (control bit 1 = 1) the load bit stays 1 after the copy. Leaving it set starts no further copy, and each new write of 1 starts exactly one copy.
- R7: In H-bridge mode with control bit 2 = 0, outputs 0 and 1 are held low while outputs 2 and 3 follow their waveforms. With bit 2 = 1, outputs 2 and 3 are held low while outputs 0 and 1 follow theirs.
- R8: In H-bridge mode, when control bit 4 (high side off) is 0, outputs 0 to 3 are forced low while control bit 9 is 0. When bit 4 is 1, outputs 0 and 2 are forced low and outputs 1 and 3 are not gated by bit 9.
- R9: Control bits 11..14 invert outputs 1, 3, 5 and 7 in either mode. Control bit 5 inverts outputs 0 to 3 only in H-bridge mode, before the direction and gating holds, and it has no effect in standard mode.
- R10: With control bit 15 set, a falling edge on the sync input, after a two-flop synchroniser, restarts all counters. With bit 15 clear, the sync input is ignored.
- R11: With control bit 10 set, each pair's wrap latches flag p and a high trip input latches flag 4. The interrupt output is the OR of the flags. Writing 1s at offset 0x8 clears the matching flags (bits 0..3 for the pairs, bit 4 for trip), and that offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 7 | Register byte offset |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| syncIn | input | 1 | External counter restart, falling edge |
| tripIn | input | 1 | Trip event, flag source only |
| pwmOut | output | 8 | PWM outputs, pair p on bits 2p and 2p+1 |
| irqOut | output | 1 | OR of latched interrupt flags |

## Verification
The hardest case to reach from the ports is the H-bridge load rule. A load bit that is still set must start no further copy, so the bench has to show that a stale request is not replayed. The bench loads one length, stages a longer one, and leaves the still-set bit alone for many periods. It then measures the output period, which must still be the old one. Only then does it write the bit again and see the new period. The sync restart is reached in a similar way. The bench waits for the low half of a long period and pulses the input there, so that a restarted counter shows up as an early return to high.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int NPAIR   = 4;
  localparam int DW      = 16;
  localparam int AW      = 7;
  localparam int PSC_W   = 3;
  localparam int PRE_W   = 1 << PSC_W;
  localparam int OUT_W   = 2 * NPAIR;
  localparam int HB_W    = 4;
  localparam int NSLOT   = 4;
  localparam int PIW     = $clog2(NPAIR);
  localparam logic [AW-1:0] ADDR_CTRL = 7'h00;
  localparam logic [AW-1:0] ADDR_CLR  = 7'h08;

  typedef struct packed {
    logic             syncEn;
    logic [NPAIR-1:0] invOdd;
    logic             irqEn;
    logic             pairEn;
    logic [PSC_W-1:0] presc;
    logic             hbInv;
    logic             hiOff;
    logic             load;
    logic             dir;
    logic             hbMode;
    logic             en;
  } ctrlT;

  typedef struct packed {
    logic             en;
    logic             hbMode;
    logic             dir;
    logic             hiOff;
    logic             hbInv;
    logic             pairEn;
    logic [NPAIR-1:0] invOdd;
  } outCfgT;

  typedef struct packed {
    logic             tick;
    logic             syncClr;
    logic [NPAIR-1:0] loadPend;
  } strobeT;
endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWrEn,
  input  logic [AW-1:0]                    regAddr,
  input  logic [DW-1:0]                    regWrData,
  output logic [DW-1:0]                    regRdData,
  input  logic                             syncIn,
  input  logic                             tripIn,
  input  logic [NPAIR-1:0]                 wrap,
  output logic [NPAIR-1:0][NSLOT-1:0][DW-1:0] stage,
  output outCfgT                           cfg,
  output strobeT                           stb,
  output logic                             irqOut
);
  localparam int GW = AW - 4;

  ctrlT               ctrlR;
  ctrlT               wNew;
  logic [NPAIR-1:0]   pending;
  logic [GW-1:0]      grp;
  logic               pairHit;
  logic [PIW-1:0]     pIdx;
  logic [1:0]         slot;
  logic [PRE_W-1:0]   prCnt;
  logic [PRE_W-1:0]   prMask;
  logic               tick;
  logic               syncA, syncB, syncC, syncHit;
  logic [NPAIR:0]     flags, setV, clrV;
  logic               ctrlWr;

  assign wNew    = ctrlT'(regWrData);
  assign grp     = regAddr[AW-1:4];
  assign slot    = regAddr[3:2];
  assign pairHit = (grp != '0) && (int'(grp) <= NPAIR);
  assign pIdx    = PIW'(grp - 1'b1);
  assign ctrlWr  = regWrEn && (regAddr == ADDR_CTRL);

  // staging registers: written any time, copied by the datapath on request
  always_ff @(posedge clk) begin
    if (!rstN) stage <= '0;
    else if (regWrEn && pairHit) stage[pIdx][slot] <= regWrData;
  end

  // control register and per-pair load bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlR   <= '0;
      pending <= '0;
    end else if (ctrlWr) begin
      ctrlR   <= wNew;
      pending <= wNew.load ? '1 : (pending & ~wrap);
    end else begin
      pending <= pending & ~wrap;
      if (ctrlR.load && !ctrlR.hbMode && (pending == '0)) ctrlR.load <= 1'b0;
    end
  end

  // prescaler: tick once every 2^(code+1) clocks
  assign prMask = PRE_W'((32'd1 << (int'(ctrlR.presc) + 1)) - 32'd1);
  assign tick   = ctrlR.en && ((prCnt & prMask) == prMask);

  always_ff @(posedge clk) begin
    if (!rstN || !ctrlR.en || syncHit) prCnt <= '0;
    else prCnt <= prCnt + 1'b1;
  end

  // sync input: two-flop synchroniser, falling edge detect, one-cycle restart
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      syncC   <= 1'b1;
      syncHit <= 1'b0;
    end else begin
      syncA   <= syncIn;
      syncB   <= syncA;
      syncC   <= syncB;
      syncHit <= ctrlR.syncEn && syncC && !syncB;
    end
  end

  // interrupt flags, write-1-to-clear
  assign setV = ctrlR.irqEn ? {tripIn, wrap} : '0;
  assign clrV = (regWrEn && regAddr == ADDR_CLR) ? regWrData[NPAIR:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else flags <= (flags & ~clrV) | setV;
  end

  assign irqOut = |flags;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) regRdData = ctrlR;
    else if (pairHit)         regRdData = stage[pIdx][slot];
  end

  assign cfg.en     = ctrlR.en;
  assign cfg.hbMode = ctrlR.hbMode;
  assign cfg.dir    = ctrlR.dir;
  assign cfg.hiOff  = ctrlR.hiOff;
  assign cfg.hbInv  = ctrlR.hbInv;
  assign cfg.pairEn = ctrlR.pairEn;
  assign cfg.invOdd = ctrlR.invOdd;

  assign stb.tick     = tick;
  assign stb.syncClr  = syncHit;
  assign stb.loadPend = pending;
endmodule

// File: rtl/pwm_quad_dp.sv
module pwm_quad_dp
  import pwm_quad_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  outCfgT                              cfg,
  input  strobeT                              stb,
  input  logic [NPAIR-1:0][NSLOT-1:0][DW-1:0] stage,
  output logic [NPAIR-1:0]                    wrap,
  output logic [NPAIR*DW-1:0]                 cntFlat,
  output logic [OUT_W-1:0]                    pwmOut
);
  logic [OUT_W-1:0] raw;
  logic [OUT_W-1:0] nxt;

  for (genvar p = 0; p < NPAIR; p++) begin : gPair
    logic [DW-1:0]             cnt;
    logic [NSLOT-1:0][DW-1:0]  act;

    assign wrap[p] = stb.tick && !stb.syncClr && (cnt == act[3]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
        act <= '0;
      end else begin
        if (!cfg.en || stb.syncClr) cnt <= '0;
        else if (stb.tick)          cnt <= (cnt == act[3]) ? '0 : cnt + DW'(1);
        if (wrap[p] && stb.loadPend[p]) act <= stage[p];
      end
    end

    assign raw[2*p]          = cnt < act[0];
    assign raw[2*p+1]        = (cnt >= act[1]) && (cnt < act[2]);
    assign cntFlat[p*DW +: DW] = cnt;
  end

  // output steering: odd inversion, H-bridge inversion, holds, master enable
  always_comb begin
    nxt = raw;
    for (int p = 0; p < NPAIR; p++) nxt[2*p+1] = raw[2*p+1] ^ cfg.invOdd[p];
    if (cfg.hbMode) begin
      if (cfg.hbInv) nxt[HB_W-1:0] = ~nxt[HB_W-1:0];
      if (cfg.dir) nxt[HB_W-1:HB_W/2] = '0;
      else         nxt[HB_W/2-1:0]    = '0;
      if (cfg.hiOff) begin
        nxt[0] = 1'b0;
        nxt[2] = 1'b0;
      end else if (!cfg.pairEn) begin
        nxt[HB_W-1:0] = '0;
      end
    end
    if (!cfg.en) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pwmOut <= '0;
    else pwmOut <= nxt;
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [AW-1:0]    regAddr,
  input  logic [DW-1:0]    regWrData,
  output logic [DW-1:0]    regRdData,
  input  logic             syncIn,
  input  logic             tripIn,
  output logic [OUT_W-1:0] pwmOut,
  output logic             irqOut
);
  logic [NPAIR-1:0][NSLOT-1:0][DW-1:0] stageW;
  outCfgT                              cfgW;
  strobeT                              stbW;
  logic [NPAIR-1:0]                    wrapW;
  logic [NPAIR*DW-1:0]                 cntW;

  pwm_quad_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .syncIn(syncIn),
    .tripIn(tripIn), .wrap(wrapW), .stage(stageW), .cfg(cfgW),
    .stb(stbW), .irqOut(irqOut)
  );

  pwm_quad_dp u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfgW), .stb(stbW), .stage(stageW),
    .wrap(wrapW), .cntFlat(cntW), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input outCfgT              cfg,
  input logic                syncClr,
  input logic [NPAIR-1:0]    wrap,
  input logic                tripIn,
  input logic [NPAIR*DW-1:0] cntFlat,
  input logic [OUT_W-1:0]    pwmOut,
  input logic                irqOut
);
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |=> (pwmOut == '0)); // R2

  AST_DIR0_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.hbMode && !cfg.dir) |=> (pwmOut[1:0] == 2'b00)); // R7

  AST_DIR1_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.hbMode && cfg.dir) |=> (pwmOut[3:2] == 2'b00)); // R7

  AST_HIGH_SIDE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.hbMode && cfg.hiOff) |=> (!pwmOut[0] && !pwmOut[2])); // R8

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    syncClr |=> (cntFlat == '0)); // R10

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past((|wrap) || tripIn)); // R11
endmodule

bind pwm_quad pwm_quad_chk u_chk (
  .clk(clk), .rstN(rstN), .cfg(cfgW), .syncClr(stbW.syncClr),
  .wrap(wrapW), .tripIn(tripIn), .cntFlat(cntW), .pwmOut(pwmOut),
  .irqOut(irqOut)
);

// File: tb/pwm_quad_test.sv
module pwm_quad_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        syncIn = 1'b1;
  logic        tripIn = 1'b0;
  logic [7:0]  pwmOut;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_quad uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .syncIn(syncIn),
    .tripIn(tripIn), .pwmOut(pwmOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic stagePair(input int p, input int a, input int b, input int c, input int len);
    wr(7'(16 + 16*p),      16'(a));
    wr(7'(16 + 16*p + 4),  16'(b));
    wr(7'(16 + 16*p + 8),  16'(c));
    wr(7'(16 + 16*p + 12), 16'(len));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic highCount(input int idx, input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwmOut[idx]) h++;
    end
  endtask

  task automatic period(input int idx, output int per);
    logic prev;
    int   t;
    per = -1;
    t = 0;
    @(negedge clk); prev = pwmOut[idx];
    while (!(pwmOut[idx] && !prev) && t < 3000) begin
      prev = pwmOut[idx]; @(negedge clk); t++;
    end
    if (t >= 3000) return;
    prev = 1'b1; t = 0;
    @(negedge clk); t = 1;
    while (!(pwmOut[idx] && !prev) && t < 3000) begin
      prev = pwmOut[idx]; @(negedge clk); t++;
    end
    if (t < 3000) per = t;
  endtask

  task automatic waitFall(input int idx);
    logic prev;
    int   t;
    t = 0;
    @(negedge clk); prev = pwmOut[idx];
    while (!(prev && !pwmOut[idx]) && t < 3000) begin
      prev = pwmOut[idx]; @(negedge clk); t++;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 outputs after reset", int'(pwmOut), 0);
    check("R1 irq after reset", int'(irqOut), 0);
    rd(7'h00, d); check("R1 control reads 0", int'(d), 0);
    rd(7'h10, d); check("R1 staged value reads 0", int'(d), 0);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    wr(7'h24, 16'h1234);
    rd(7'h24, d); check("R4 staged readback pair1 slot1", int'(d), 'h1234);
    wr(7'h4C, 16'h00AB);
    rd(7'h4C, d); check("R4 staged readback pair3 length", int'(d), 'hAB);
    wr(7'h24, 16'h0000);
    wr(7'h4C, 16'h0000);
    wr(7'h08, 16'h001F);
    rd(7'h08, d); check("R11 clear register reads 0", int'(d), 0);
  endtask

  task automatic t_standardLoad();
    logic [15:0] d;
    int per, h;
    stagePair(0, 2, 1, 3, 3);
    wr(7'h00, 16'h0009);
    idle(40);
    rd(7'h00, d); check("R5 load bit self-clears in standard mode", int'(d[3]), 0);
    period(0, per); check("R3 period code 0, length 3", per, 8);
    highCount(0, 80, h); check("R4 even output high while count < A", h, 40);
    highCount(1, 80, h); check("R4 odd output high for B <= count < C", h, 40);
    wr(7'h1C, 16'd7);
    idle(20);
    period(0, per); check("R4 staged length has no effect before load", per, 8);
    wr(7'h00, 16'h0009);
    idle(40);
    period(0, per); check("R5 loaded length changes period", per, 16);
    wr(7'h1C, 16'd3);
    wr(7'h00, 16'h0009);
    idle(40);
  endtask

  task automatic t_prescale();
    int per;
    wr(7'h00, 16'h0081);
    idle(80);
    period(0, per); check("R3 prescaler code 2 gives /8 ticks", per, 32);
    wr(7'h00, 16'h0141);
    idle(300);
    period(0, per); check("R3 prescaler code 5 gives /64 ticks", per, 256);
    wr(7'h00, 16'h0001);
    idle(300);
  endtask

  task automatic t_disable();
    int h;
    wr(7'h00, 16'h0000);
    idle(2);
    h = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pwmOut != 0) h++;
    end
    check("R2 all outputs low while disabled", h, 0);
  endtask

  task automatic t_invertStd();
    int h;
    stagePair(0, 0, 0, 0, 3);
    wr(7'h00, 16'h0809);
    idle(40);
    highCount(1, 40, h); check("R9 inverted odd output 1 stays high", h, 40);
    highCount(0, 40, h); check("R9 even output 0 low with A=0", h, 0);
    wr(7'h00, 16'h0821);
    idle(10);
    highCount(0, 40, h); check("R9 H-bridge inversion ignored in standard mode", h, 0);
  endtask

  task automatic t_hbridge();
    logic [15:0] d;
    int h, per;
    stagePair(0, 2, 1, 3, 3);
    stagePair(1, 2, 1, 3, 3);
    wr(7'h00, 16'h020B);
    idle(40);
    rd(7'h00, d); check("R6 load bit stays set in H-bridge mode", int'(d[3]), 1);
    highCount(0, 80, h); check("R7 dir 0 holds output 0 low", h, 0);
    highCount(1, 80, h); check("R7 dir 0 holds output 1 low", h, 0);
    highCount(2, 80, h); check("R7 dir 0 lets output 2 drive", h, 40);
    wr(7'h00, 16'h020F);
    idle(20);
    highCount(2, 80, h); check("R7 dir 1 holds output 2 low", h, 0);
    highCount(3, 80, h); check("R7 dir 1 holds output 3 low", h, 0);
    highCount(0, 80, h); check("R7 dir 1 lets output 0 drive", h, 40);
    wr(7'h1C, 16'd7);
    idle(60);
    period(0, per); check("R6 set load bit does not reload", per, 8);
    wr(7'h00, 16'h020F);
    idle(40);
    period(0, per); check("R6 new write of 1 reloads", per, 16);
    wr(7'h1C, 16'd3);
    wr(7'h00, 16'h020F);
    idle(40);
    wr(7'h00, 16'h0007);
    idle(4);
    h = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (pwmOut[3:0] != 0) h++;
    end
    check("R8 pair enable 0 forces outputs 0..3 low", h, 0);
    wr(7'h00, 16'h0017);
    idle(4);
    highCount(0, 80, h); check("R8 high side off forces output 0 low", h, 0);
    highCount(1, 80, h); check("R8 high side off leaves output 1 driving", h, 40);
    stagePair(0, 1, 1, 3, 3);
    wr(7'h00, 16'h020F);
    idle(40);
    highCount(0, 80, h); check("R9 output 0 without H-bridge inversion", h, 20);
    wr(7'h00, 16'h022F);
    idle(40);
    highCount(0, 80, h); check("R9 output 0 with H-bridge inversion", h, 60);
  endtask

  task automatic t_sync();
    int h;
    stagePair(0, 50, 0, 0, 99);
    wr(7'h00, 16'h8009);
    idle(40);
    waitFall(0);
    idle(20);
    syncIn = 1'b0;
    idle(4);
    syncIn = 1'b1;
    idle(8);
    highCount(0, 1, h); check("R10 falling sync edge restarts counters", h, 1);
    wr(7'h00, 16'h0001);
    waitFall(0);
    idle(20);
    syncIn = 1'b0;
    idle(4);
    syncIn = 1'b1;
    idle(8);
    highCount(0, 1, h); check("R10 sync ignored when disabled", h, 0);
  endtask

  task automatic t_irq();
    check("R11 no flag while interrupts disabled", int'(irqOut), 0);
    wr(7'h00, 16'h0401);
    idle(20);
    check("R11 wrap raises interrupt", int'(irqOut), 1);
    wr(7'h00, 16'h0400);
    idle(2);
    check("R11 flags stay latched", int'(irqOut), 1);
    wr(7'h08, 16'h000F);
    idle(2);
    check("R11 pair flags cleared by write of 1s", int'(irqOut), 0);
    @(negedge clk); tripIn = 1'b1;
    @(negedge clk); tripIn = 1'b0;
    idle(2);
    check("R11 trip raises interrupt", int'(irqOut), 1);
    wr(7'h08, 16'h000F);
    idle(2);
    check("R11 pair clear bits leave trip flag", int'(irqOut), 1);
    wr(7'h08, 16'h0010);
    idle(2);
    check("R11 bit 4 clears trip flag", int'(irqOut), 0);
    wr(7'h00, 16'h0000);
    @(negedge clk); tripIn = 1'b1;
    @(negedge clk); tripIn = 1'b0;
    idle(2);
    check("R11 trip ignored with interrupts disabled", int'(irqOut), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_standardLoad();
    t_prescale();
    t_disable();
    t_invertStd();
    t_hbridge();
    t_sync();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule